// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM Core

This block is a small synchronous static memory whose data bus never needs an idle cycle between a read and a write. Every command (address, read/write choice, byte enables, burst advance) is taken on a rising clock edge. Write data arrives a fixed number of enabled edges after its command. That delay equals the read latency of the selected read path, so a write's data slot and a read's data slot never collide and commands can alternate on every cycle.

A static mode input picks the read path. In flow-through mode, read data comes straight from the array after the command edge. In pipelined mode it passes through one more output register. A two-bit burst counter lets one command be followed by up to three more accesses, and then wraps, without presenting a new address. Three chip enables gate acceptance of new commands. An active-low clock enable freezes the whole block. An asynchronous output enable and a sleep input can both switch the data outputs off at once.

The data bus is split into an input word and an output word with a separate drive-enable output. The storage is a register array, so the block suits small on-chip buffers that must keep a bus fully busy.

Top module: `nbt_sram`

## Requirements
- R1: After reset the data outputs are not driven: `dout_oe` is 0 and `dout` reads all zeros.
- R2: With `pipe_sel`=0 (flow-through), a read command taken at edge t puts the stored word on `dout` with `dout_oe`=1 in the cycle that follows edge t.
- R3: With `pipe_sel`=1 (pipelined), a read command taken at edge t shows nothing after edge t and puts its word on `dout` after edge t+1.
- R4: The write data of a write command taken at edge t is sampled on `wdata` at the next enabled edge in flow-through mode and at the second enabled edge in pipelined mode. Reads and writes may alternate on every cycle with no idle cycle, and each read returns the right word.
- R5: `bw_n` bit i, active low and sampled with the command, enables the byte `wdata[i*BYTE_W +: BYTE_W]`. Bytes that are not enabled keep their old value.
- R6: A new command is accepted only when `cs1_n`=0, `cs2_n`=0 and `cs3`=1. Any other combination deselects: nothing is written and nothing is driven.
- R7: With `adv`=1 after an accepted read or write, the block performs the same kind of access at the next burst address. The upper address bits are kept. Burst step k (0..3, wrapping) uses low bits start+k mod 4 when `order_il`=0 and start XOR k when `order_il`=1. `adv`=1 with no burst active deselects.
- R8: An edge with `ce_n`=1 changes nothing: commands, the pending write, its data slot and the output register all hold. Write data slots count enabled edges only.
- R9: In pipelined mode, a read of an address whose write data is being taken at the same edge returns the new data for the enabled bytes.
- R10: `oe_n`=1 forces `dout_oe`=0 and `dout`=0 at once, without waiting for a clock edge; releasing it restores the pending read word.
- R11: `sleep`=1 switches the outputs off at once. A command sampled while `sleep`=1 is treated as a deselect and ends any burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Clock enable, active low |
| cs1_n | input | 1 | Chip enable 1, active low |
| cs2_n | input | 1 | Chip enable 2, active low |
| cs3 | input | 1 | Chip enable 3, active high |
| we_n | input | 1 | 0 = write command, 1 = read command |
| adv | input | 1 | Continue the current burst |
| bw_n | input | BYTES | Byte write enables, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | BYTES*BYTE_W | Late write data |
| pipe_sel | input | 1 | 1 = pipelined read path, 0 = flow-through (static) |
| order_il | input | 1 | 0 = linear burst order, 1 = interleaved (static) |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down, active high |
| dout | output | BYTES*BYTE_W | Read data, zero when not driven |
| dout_oe | output | 1 | Read data is being driven |

## Verification
The bench builds the core with two 9-bit bytes and a 4-bit address. The odd byte width shows whether lane boundaries are placed correctly, and the 16-word array lets a four-word burst, its wrap and several separate test words sit side by side. Both read paths are run in one session: the mode is changed while the pipeline is empty. This brings within reach full-rate read/write alternation in each mode and the same-edge bypass of a pending write in pipelined mode. Clock-enable freezes are placed between a write command and its data slot, and between a read command and its output load.

// File: rtl/nbt_sram_pkg.sv
package nbt_sram_pkg;

  typedef enum logic [1:0] {
    K_IDLE  = 2'd0,
    K_READ  = 2'd1,
    K_WRITE = 2'd2
  } burst_kind_t;

  // Low two address bits for burst step `step` from offset `start`.
  function automatic logic [1:0] burst_off(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       interleave);
    logic [1:0] r;
    if (interleave) r = start ^ step;
    else            r = start + step;
    return r;
  endfunction

endpackage

// File: rtl/nbt_cmd_decode.sv
module nbt_cmd_decode
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sleep,
  input  logic              cs1_n,
  input  logic              cs2_n,
  input  logic              cs3,
  input  logic              we_n,
  input  logic              adv,
  input  logic [BYTES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              order_il,
  output logic              iss_valid,
  output logic              iss_wr,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [BYTES-1:0]  iss_bw_n
);

  localparam int HI_W = ADDR_W - 2;

  burst_kind_t       kind;
  logic [HI_W-1:0]   hi_q;
  logic [1:0]        start_q;
  logic [1:0]        step_q;
  logic [1:0]        next_step;
  logic              sel_all;
  logic              burst_live;

  assign sel_all    = !cs1_n && !cs2_n && cs3;
  assign burst_live = (kind != K_IDLE);
  assign next_step  = step_q + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind      <= K_IDLE;
      hi_q      <= '0;
      start_q   <= '0;
      step_q    <= '0;
      iss_valid <= 1'b0;
      iss_wr    <= 1'b0;
      iss_addr  <= '0;
      iss_bw_n  <= '1;
    end else if (en) begin
      iss_bw_n <= bw_n;
      if (sleep) begin
        kind      <= K_IDLE;
        iss_valid <= 1'b0;
      end else if (!adv) begin
        if (sel_all) begin
          kind      <= we_n ? K_READ : K_WRITE;
          hi_q      <= addr[ADDR_W-1:2];
          start_q   <= addr[1:0];
          step_q    <= 2'd0;
          iss_valid <= 1'b1;
          iss_wr    <= !we_n;
          iss_addr  <= addr;
        end else begin
          kind      <= K_IDLE;
          iss_valid <= 1'b0;
        end
      end else if (burst_live) begin
        step_q    <= next_step;
        iss_valid <= 1'b1;
        iss_wr    <= (kind == K_WRITE);
        iss_addr  <= {hi_q, burst_off(start_q, next_step, order_il)};
      end else begin
        iss_valid <= 1'b0;
      end
    end
  end

  // R6: an enabled edge without all three chip enables issues nothing
  a_r6_deselect_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sleep && !adv && !sel_all) |=> !iss_valid);

  // R11: a command sampled in sleep issues nothing and ends the burst
  a_r11_sleep_drops_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sleep) |=> (!iss_valid && !burst_live));

  // R7: every continued burst access moves the step counter by one
  a_r7_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sleep && adv && burst_live) |=> (step_q == $past(step_q) + 2'd1));

  // R7: a continued burst keeps the upper address bits
  a_r7_burst_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sleep && adv && burst_live && iss_valid)
      |=> (iss_addr[ADDR_W-1:2] == $past(iss_addr[ADDR_W-1:2])));

endmodule

// File: rtl/nbt_late_pipe.sv
module nbt_late_pipe #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              pipe_sel,
  input  logic              iss_valid,
  input  logic              iss_wr,
  input  logic [ADDR_W-1:0] iss_addr,
  input  logic [BYTES-1:0]  iss_bw_n,
  output logic              commit_we,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [BYTES-1:0]  commit_bw_n,
  output logic              rd_now,
  output logic              byp_hit,
  output logic [BYTES-1:0]  byp_bw_n
);

  logic              s2_valid;
  logic              s2_wr;
  logic [ADDR_W-1:0] s2_addr;
  logic [BYTES-1:0]  s2_bw_n;
  logic              s1_write;
  logic              s2_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_wr    <= 1'b0;
      s2_addr  <= '0;
      s2_bw_n  <= '1;
    end else if (en) begin
      s2_valid <= iss_valid;
      s2_wr    <= iss_wr;
      s2_addr  <= iss_addr;
      s2_bw_n  <= iss_bw_n;
    end
  end

  assign s1_write = iss_valid && iss_wr;
  assign s2_write = s2_valid && s2_wr;

  // Write slot: one enabled edge late in flow-through, two when pipelined
  assign commit_we   = en && (pipe_sel ? s2_write : s1_write);
  assign commit_addr = pipe_sel ? s2_addr : iss_addr;
  assign commit_bw_n = pipe_sel ? s2_bw_n : iss_bw_n;

  assign rd_now   = iss_valid && !iss_wr;
  assign byp_hit  = pipe_sel && s2_write && (s2_addr == iss_addr);
  assign byp_bw_n = s2_bw_n;

  // R8: a disabled edge leaves the whole command pipeline untouched
  a_r8_freeze_pipe: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable({s2_valid, s2_wr, s2_addr, s2_bw_n,
                     iss_valid, iss_wr, iss_addr}));

endmodule

// File: rtl/nbt_store.sv
module nbt_store #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [BYTES-1:0]        wbw_n,
  input  logic [BYTES*BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [BYTES*BYTE_W-1:0] rdata
);

  localparam int DW    = BYTES * BYTE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] wmask;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign wmask[b*BYTE_W +: BYTE_W] = {BYTE_W{!wbw_n[b]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= (mem[waddr] & ~wmask) | (wdata & wmask);
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/nbt_read_path.sv
module nbt_read_path #(
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    pipe_sel,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic                    rd_now,
  input  logic [BYTES*BYTE_W-1:0] arr_data,
  input  logic                    byp_hit,
  input  logic [BYTES-1:0]        byp_bw_n,
  input  logic [BYTES*BYTE_W-1:0] wdata,
  output logic [BYTES*BYTE_W-1:0] dout,
  output logic                    dout_oe
);

  localparam int DW = BYTES * BYTE_W;

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0]    old_w,
                                               input logic [DW-1:0]    new_w,
                                               input logic [BYTES-1:0] keep_n);
    logic [DW-1:0] r;
    for (int b = 0; b < BYTES; b++)
      r[b*BYTE_W +: BYTE_W] = keep_n[b] ? old_w[b*BYTE_W +: BYTE_W]
                                        : new_w[b*BYTE_W +: BYTE_W];
    return r;
  endfunction

  logic [DW-1:0] fresh;
  logic [DW-1:0] out_q;
  logic          out_act;
  logic [DW-1:0] sel_data;
  logic          active;

  assign fresh = lane_merge(arr_data, wdata, byp_hit ? byp_bw_n : '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      out_act <= 1'b0;
    end else if (en) begin
      out_act <= rd_now;
      if (rd_now) out_q <= fresh;
    end
  end

  assign sel_data = pipe_sel ? out_q : arr_data;
  assign active   = pipe_sel ? out_act : rd_now;
  assign dout_oe  = active && !oe_n && !sleep;
  assign dout     = dout_oe ? sel_data : '0;

  // R3: a read issued in pipelined mode is loaded into the output stage
  a_r3_out_load: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pipe_sel && rd_now) |=> out_act);

endmodule

// File: rtl/nbt_sram.sv
module nbt_sram #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce_n,
  input  logic                    cs1_n,
  input  logic                    cs2_n,
  input  logic                    cs3,
  input  logic                    we_n,
  input  logic                    adv,
  input  logic [BYTES-1:0]        bw_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES*BYTE_W-1:0] wdata,
  input  logic                    pipe_sel,
  input  logic                    order_il,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [BYTES*BYTE_W-1:0] dout,
  output logic                    dout_oe
);

  localparam int DW = BYTES * BYTE_W;

  logic              en;
  logic              iss_valid;
  logic              iss_wr;
  logic [ADDR_W-1:0] iss_addr;
  logic [BYTES-1:0]  iss_bw_n;
  logic              commit_we;
  logic [ADDR_W-1:0] commit_addr;
  logic [BYTES-1:0]  commit_bw_n;
  logic              rd_now;
  logic              byp_hit;
  logic [BYTES-1:0]  byp_bw_n;
  logic [DW-1:0]     arr_data;

  assign en = !ce_n;

  nbt_cmd_decode #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_dec (
    .clk(clk), .rst_n(rst_n), .en(en), .sleep(sleep),
    .cs1_n(cs1_n), .cs2_n(cs2_n), .cs3(cs3), .we_n(we_n), .adv(adv),
    .bw_n(bw_n), .addr(addr), .order_il(order_il),
    .iss_valid(iss_valid), .iss_wr(iss_wr), .iss_addr(iss_addr),
    .iss_bw_n(iss_bw_n)
  );

  nbt_late_pipe #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_pipe (
    .clk(clk), .rst_n(rst_n), .en(en), .pipe_sel(pipe_sel),
    .iss_valid(iss_valid), .iss_wr(iss_wr), .iss_addr(iss_addr),
    .iss_bw_n(iss_bw_n),
    .commit_we(commit_we), .commit_addr(commit_addr),
    .commit_bw_n(commit_bw_n), .rd_now(rd_now),
    .byp_hit(byp_hit), .byp_bw_n(byp_bw_n)
  );

  nbt_store #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(commit_we), .waddr(commit_addr),
    .wbw_n(commit_bw_n), .wdata(wdata), .raddr(iss_addr),
    .rdata(arr_data)
  );

  nbt_read_path #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .en(en), .pipe_sel(pipe_sel),
    .oe_n(oe_n), .sleep(sleep), .rd_now(rd_now), .arr_data(arr_data),
    .byp_hit(byp_hit), .byp_bw_n(byp_bw_n), .wdata(wdata),
    .dout(dout), .dout_oe(dout_oe)
  );

endmodule

// File: tb/sim_nbt_sram.sv
module sim_nbt_sram;

  localparam int AW = 4;
  localparam int NB = 2;
  localparam int BW = 9;
  localparam int DW = NB * BW;
  localparam logic [2:0] ON  = 3'b111;
  localparam logic [2:0] OFF = 3'b000;

  localparam logic [DW-1:0] D1  = 18'h2A5C3;
  localparam logic [DW-1:0] D2  = 18'h13E7F;
  localparam logic [DW-1:0] D3  = 18'h0BEEF;
  localparam logic [DW-1:0] D4  = 18'h30F11;
  localparam logic [DW-1:0] D5  = 18'h15ABC;
  localparam logic [DW-1:0] E0  = 18'h01111;
  localparam logic [DW-1:0] E1  = 18'h12222;
  localparam logic [DW-1:0] E2  = 18'h23333;
  localparam logic [DW-1:0] E3  = 18'h30444;
  localparam logic [DW-1:0] F13 = 18'h26DEF;
  localparam logic [DW-1:0] F14 = 18'h07123;
  localparam logic [DW-1:0] BAD = 18'h3FFFF;
  localparam logic [DW-1:0] M3  = {D1[17:9], D4[8:0]};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b0, cs1_n = 1'b1, cs2_n = 1'b1, cs3 = 1'b0;
  logic we_n = 1'b1, adv = 1'b0;
  logic [NB-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic pipe_sel = 1'b0, order_il = 1'b0, oe_n = 1'b0, sleep = 1'b0;
  logic [DW-1:0] dout;
  logic dout_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  nbt_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cs1_n(cs1_n), .cs2_n(cs2_n),
    .cs3(cs3), .we_n(we_n), .adv(adv), .bw_n(bw_n), .addr(addr),
    .wdata(wdata), .pipe_sel(pipe_sel), .order_il(order_il),
    .oe_n(oe_n), .sleep(sleep), .dout(dout), .dout_oe(dout_oe)
  );

  // e = {cs3 asserted, cs2 asserted, cs1 asserted}
  task automatic drive(input logic [2:0] e, input logic wr, input logic a_adv,
                       input logic [AW-1:0] a, input logic [NB-1:0] bwn,
                       input logic [DW-1:0] wd);
    cs1_n = !e[0]; cs2_n = !e[1]; cs3 = e[2];
    we_n = !wr; adv = a_adv; addr = a; bw_n = bwn; wdata = wd;
    @(negedge clk);
  endtask

  task automatic idle(input logic [DW-1:0] wd);
    drive(OFF, 1'b0, 1'b0, '0, '1, wd);
  endtask

  task automatic chk(input string req, input logic exp_oe, input logic [DW-1:0] exp_d);
    checks++;
    if (dout_oe !== exp_oe || dout !== exp_d) begin
      errors++;
      $display("FAIL %s: dout_oe=%0b dout=%05h expected dout_oe=%0b dout=%05h",
               req, dout_oe, dout, exp_oe, exp_d);
    end
  endtask

  task automatic t_reset;
    chk("R1 reset", 1'b0, '0);
  endtask

  task automatic t_flow_alternate;
    drive(ON, 1'b1, 1'b0, 4'd3, 2'b00, '0);
    drive(ON, 1'b0, 1'b0, 4'd3, 2'b11, D1);
    chk("R2 R4 flow read right after write", 1'b1, D1);
    drive(ON, 1'b1, 1'b0, 4'd4, 2'b00, '0);
    drive(ON, 1'b0, 1'b0, 4'd4, 2'b11, D2);
    chk("R4 flow second alternation", 1'b1, D2);
    drive(ON, 1'b0, 1'b0, 4'd3, 2'b11, '0);
    chk("R2 flow read older word", 1'b1, D1);
    idle('0);
    chk("R2 no read no drive", 1'b0, '0);
  endtask

  task automatic t_byte_lanes;
    drive(ON, 1'b1, 1'b0, 4'd3, 2'b10, '0);
    drive(ON, 1'b0, 1'b0, 4'd3, 2'b11, D4);
    chk("R5 only low 9-bit lane written", 1'b1, M3);
    drive(ON, 1'b1, 1'b0, 4'd4, 2'b11, '0);
    drive(ON, 1'b0, 1'b0, 4'd4, 2'b11, BAD);
    chk("R5 no lane enabled keeps word", 1'b1, D2);
  endtask

  task automatic t_chip_enables;
    logic [2:0] part [3];
    part[0] = 3'b110; part[1] = 3'b101; part[2] = 3'b011;
    for (int i = 0; i < 3; i++) begin
      drive(part[i], 1'b1, 1'b0, 4'd3, 2'b00, '0);
      drive(ON, 1'b0, 1'b0, 4'd3, 2'b11, BAD);
      chk("R6 partial enable write ignored", 1'b1, M3);
      drive(part[i], 1'b0, 1'b0, 4'd3, 2'b11, '0);
      chk("R6 partial enable read not driven", 1'b0, '0);
    end
  endtask

  task automatic t_burst;
    order_il = 1'b0;
    drive(ON, 1'b1, 1'b0, 4'd10, 2'b00, '0);
    drive(OFF, 1'b1, 1'b1, 4'd0, 2'b00, E0);
    drive(OFF, 1'b1, 1'b1, 4'd0, 2'b00, E1);
    drive(OFF, 1'b1, 1'b1, 4'd0, 2'b00, E2);
    idle(E3);
    drive(ON, 1'b0, 1'b0, 4'd10, 2'b11, '0); chk("R7 linear step0 at 10", 1'b1, E0);
    drive(ON, 1'b0, 1'b0, 4'd11, 2'b11, '0); chk("R7 linear step1 at 11", 1'b1, E1);
    drive(ON, 1'b0, 1'b0, 4'd8,  2'b11, '0); chk("R7 linear wrap step2 at 8", 1'b1, E2);
    drive(ON, 1'b0, 1'b0, 4'd9,  2'b11, '0); chk("R7 linear step3 at 9", 1'b1, E3);
    idle('0);
    order_il = 1'b1;
    drive(ON, 1'b0, 1'b0, 4'd9, 2'b11, '0);  chk("R7 interleave start 9", 1'b1, E3);
    drive(OFF, 1'b0, 1'b1, 4'd0, 2'b11, '0); chk("R7 interleave 1^1 -> 8", 1'b1, E2);
    drive(OFF, 1'b0, 1'b1, 4'd0, 2'b11, '0); chk("R7 interleave 1^2 -> 11", 1'b1, E1);
    drive(OFF, 1'b0, 1'b1, 4'd0, 2'b11, '0); chk("R7 interleave 1^3 -> 10", 1'b1, E0);
    drive(OFF, 1'b0, 1'b1, 4'd0, 2'b11, '0); chk("R7 burst wraps to start", 1'b1, E3);
    idle('0);
    order_il = 1'b0;
    drive(OFF, 1'b0, 1'b1, 4'd0, 2'b11, '0);
    chk("R7 advance without burst deselects", 1'b0, '0);
  endtask

  task automatic t_sleep_cmd;
    sleep = 1'b1;
    drive(ON, 1'b1, 1'b0, 4'd3, 2'b00, '0);
    sleep = 1'b0;
    drive(ON, 1'b0, 1'b0, 4'd3, 2'b11, BAD);
    chk("R11 write sampled in sleep dropped", 1'b1, M3);
    idle('0);
  endtask

  task automatic t_pipe_alternate;
    idle('0);
    pipe_sel = 1'b1;
    drive(ON, 1'b1, 1'b0, 4'd5, 2'b00, '0);
    drive(ON, 1'b0, 1'b0, 4'd5, 2'b11, '0);
    chk("R3 pipelined read not yet out", 1'b0, '0);
    idle(D3);
    chk("R3 R9 pipelined read bypasses pending write", 1'b1, D3);
    idle('0);
    chk("R3 output released", 1'b0, '0);
    drive(ON, 1'b0, 1'b0, 4'd3, 2'b11, '0);
    chk("R3 latency two edges", 1'b0, '0);
    idle('0);
    chk("R3 pipelined read of stored word", 1'b1, M3);
    drive(ON, 1'b1, 1'b0, 4'd13, 2'b00, '0);
    drive(ON, 1'b0, 1'b0, 4'd13, 2'b11, '0);
    drive(ON, 1'b1, 1'b0, 4'd14, 2'b00, F13);
    chk("R4 R9 pipelined full-rate read 13", 1'b1, F13);
    drive(ON, 1'b0, 1'b0, 4'd14, 2'b11, '0);
    chk("R4 write slot drives nothing", 1'b0, '0);
    idle(F14);
    chk("R4 R9 pipelined full-rate read 14", 1'b1, F14);
    idle('0);
  endtask

  task automatic t_clock_enable;
    drive(ON, 1'b0, 1'b0, 4'd10, 2'b11, '0);
    ce_n = 1'b1;
    idle('0); chk("R8 frozen edge holds read", 1'b0, '0);
    idle('0); chk("R8 second frozen edge", 1'b0, '0);
    ce_n = 1'b0;
    idle('0); chk("R8 read resumes after freeze", 1'b1, E0);
    ce_n = 1'b1;
    idle('0); chk("R8 output register held", 1'b1, E0);
    oe_n = 1'b1; #1; chk("R10 output enable off at once", 1'b0, '0);
    oe_n = 1'b0; #1; chk("R10 output restored", 1'b1, E0);
    sleep = 1'b1; #1; chk("R11 sleep turns output off", 1'b0, '0);
    sleep = 1'b0; #1; chk("R11 output back after sleep", 1'b1, E0);
    ce_n = 1'b0;
    idle('0); chk("R8 output released after enable", 1'b0, '0);
    drive(ON, 1'b1, 1'b0, 4'd12, 2'b00, '0);
    ce_n = 1'b1;
    idle(BAD);
    ce_n = 1'b0;
    idle('0);
    idle(D5);
    drive(ON, 1'b0, 1'b0, 4'd12, 2'b11, '0);
    idle('0);
    chk("R8 write slot counts enabled edges", 1'b1, D5);
  endtask

  task automatic finish_run;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_flow_alternate;
    t_byte_lanes;
    t_chip_enables;
    t_burst;
    t_sleep_cmd;
    t_pipe_alternate;
    t_clock_enable;
    finish_run;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_run;
    end
  end

endmodule